// File: doc/BRIEF.md
# Elastic Dejitter Bit Buffer

This block sits between a clock-and-data recovery stage and the rest of a receive path. It moves a dual-rail bipolar bit stream out of a noisy recovered-clock domain and into a smooth local read-clock domain. Each symbol is a positive-pulse bit and a negative-pulse bit. Symbols are written into a circular buffer on every rising edge of the write clock and are read back in order on every rising edge of the read clock. The buffer absorbs the phase wander between the two clocks. The read clock comes from outside the block.

The write pointer crosses into the read domain as a Gray code through a two-flop synchronizer. The read side then computes the fill level. When the fill level comes close to empty or full, a limit flag goes high. When the buffer would overrun or run dry, the read pointer jumps back to half a buffer behind the write pointer. An active-low recenter input triggers the same jump once for each low pulse. A bypass input sends the incoming pair straight to the outputs and leaves the buffer out of the path.

Top module: `dejitter_buf`

## Requirements
- R1: While rst_ni is low and directly after it, pos_o, neg_o and limit_o are 0 (with bypass_i low).
- R2: After reset, no symbol leaves the buffer until half of DEPTH (64 of 128) symbols are buffered. Until then the outputs stay 0 and limit_o stays low.
- R3: When both clocks run at the same rate, every written symbol appears on pos_o/neg_o exactly once, in write order. The outputs are registered and change on the rising edge of rclk_i, and limit_o stays low.
- R4: One low pulse on recenter_ni puts the read pointer half of DEPTH behind the write pointer. This happens exactly once, when the pulse returns high, and limit_o is high for exactly one rclk_i cycle per pulse.
- R5: limit_o goes high while the fill level is within LIM (4) positions of empty or of full.
- R6: When the fill level reaches DEPTH-2 or drops to 0, the block recenters on its own, holds limit_o high for at least one rclk_i cycle, and then resumes output without any external command. limit_o then clears again.
- R7: When the write clock runs slower than the read clock, the buffer drains, limit_o goes high, and the buffer recovers by recentering.
- R8: While bypass_i is 1, pos_o equals pos_i and neg_o equals neg_i combinationally, so the buffer has no effect on the outputs.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| wclk_i | input | 1 | Recovered (write) clock |
| rclk_i | input | 1 | Smoothed (read) clock |
| rst_ni | input | 1 | Asynchronous active-low reset, both domains |
| pos_i | input | 1 | Positive-pulse data bit, sampled on wclk_i |
| neg_i | input | 1 | Negative-pulse data bit, sampled on wclk_i |
| recenter_ni | input | 1 | Active-low recenter request; acts once per low pulse |
| bypass_i | input | 1 | 1: pass pos_i/neg_i straight through |
| pos_o | output | 1 | Positive-pulse data out |
| neg_o | output | 1 | Negative-pulse data out |
| limit_o | output | 1 | Fill level near empty or full, or a recenter happened |

## Verification
The hardest conditions to reach from the ports are the automatic recenters near full and near empty, because the fill level is not visible. The stimulus gets there by changing the write-clock period during the run. A write clock 10% faster than the read clock pushes the buffer through several overrun slips. A write clock 10% slower drains it through underrun slips. The bench writes a 7-bit maximal-length pseudo-random sequence. It checks in-order delivery by testing that the output obeys the same recurrence, so it can do this without knowing the latency.

// File: rtl/dj_pkg.sv
package dj_pkg;
  typedef struct packed {
    logic p;
    logic n;
  } sym_t;

  localparam int unsigned SYNC_STAGES = 2;
endpackage

// File: rtl/dj_sync.sv
module dj_sync #(
  parameter int unsigned W = 1,
  parameter logic [W-1:0] RST_VAL = '0
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic [W-1:0] d_i,
  output logic [W-1:0] q_o
);
  logic [W-1:0] s1_q, s2_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      s1_q <= RST_VAL;
      s2_q <= RST_VAL;
    end else begin
      s1_q <= d_i;
      s2_q <= s1_q;
    end
  end

  assign q_o = s2_q;

  // R3
  sync_delay_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    q_o == $past(d_i, 2));
endmodule

// File: rtl/dj_wr_ctl.sv
module dj_wr_ctl #(
  parameter int unsigned DEPTH = 128,
  localparam int unsigned AW = $clog2(DEPTH),
  localparam int unsigned PW = AW + 1
) (
  input  logic          wclk_i,
  input  logic          rst_ni,
  output logic [AW-1:0] waddr_o,
  output logic [PW-1:0] wgray_o
);
  logic [PW-1:0] wptr_q, wptr_nx;

  assign wptr_nx = wptr_q + PW'(1);

  always_ff @(posedge wclk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      wptr_q  <= '0;
      wgray_o <= '0;
    end else begin
      wptr_q  <= wptr_nx;
      wgray_o <= wptr_nx ^ (wptr_nx >> 1);
    end
  end

  assign waddr_o = wptr_q[AW-1:0];

  // R3
  gray_step_chk: assert property (@(posedge wclk_i) disable iff (!rst_ni)
    $countones(wgray_o ^ $past(wgray_o)) <= 1);
endmodule

// File: rtl/dj_ram.sv
module dj_ram
  import dj_pkg::*;
#(
  parameter int unsigned DEPTH = 128,
  localparam int unsigned AW = $clog2(DEPTH)
) (
  input  logic          wclk_i,
  input  logic [AW-1:0] waddr_i,
  input  sym_t          wdata_i,
  input  logic          rclk_i,
  input  logic          rst_ni,
  input  logic          re_i,
  input  logic [AW-1:0] raddr_i,
  output sym_t          rdata_o
);
  sym_t mem_q [DEPTH];

  always_ff @(posedge wclk_i) mem_q[waddr_i] <= wdata_i;

  always_ff @(posedge rclk_i or negedge rst_ni) begin
    if (!rst_ni)   rdata_o <= '0;
    else if (re_i) rdata_o <= mem_q[raddr_i];
  end
endmodule

// File: rtl/dj_rd_ctl.sv
module dj_rd_ctl #(
  parameter int unsigned DEPTH = 128,
  parameter int unsigned LIM = 4,
  parameter int unsigned SLIP_GAP = 2,
  localparam int unsigned AW = $clog2(DEPTH),
  localparam int unsigned PW = AW + 1
) (
  input  logic          rclk_i,
  input  logic          rst_ni,
  input  logic [PW-1:0] wgray_i,
  input  logic          recenter_ni,
  output logic          re_o,
  output logic [AW-1:0] raddr_o,
  output logic          limit_o
);
  localparam logic [PW-1:0] MID    = PW'(DEPTH / 2);
  localparam logic [PW-1:0] LO_LIM = PW'(LIM);
  localparam logic [PW-1:0] HI_LIM = PW'(DEPTH - LIM);
  localparam logic [PW-1:0] HI_SLP = PW'(DEPTH - SLIP_GAP);

  logic          rc_s, rc_q, rc_evt;
  logic [PW-1:0] wbin, rptr_q, occ;
  logic          run_q, slip, jump;

  dj_sync #(.W(1), .RST_VAL(1'b1)) u_rc_sync (
    .clk_i (rclk_i),
    .rst_ni(rst_ni),
    .d_i   (recenter_ni),
    .q_o   (rc_s)
  );

  always_ff @(posedge rclk_i or negedge rst_ni) begin
    if (!rst_ni) rc_q <= 1'b1;
    else         rc_q <= rc_s;
  end

  // low pulse ends: act once
  assign rc_evt = rc_s & ~rc_q & run_q;

  always_comb begin
    wbin[PW-1] = wgray_i[PW-1];
    for (int i = PW - 2; i >= 0; i--) wbin[i] = wbin[i+1] ^ wgray_i[i];
  end

  assign occ  = wbin - rptr_q;
  assign slip = run_q & ((occ == '0) | (occ >= HI_SLP));
  assign jump = slip | rc_evt;
  assign re_o = run_q & ~jump;

  always_ff @(posedge rclk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      run_q   <= 1'b0;
      rptr_q  <= '0;
      limit_o <= 1'b0;
    end else begin
      if (!run_q && occ >= MID) run_q <= 1'b1;
      if (jump)      rptr_q <= wbin - MID;
      else if (re_o) rptr_q <= rptr_q + PW'(1);
      limit_o <= jump | (run_q & ((occ <= LO_LIM) | (occ >= HI_LIM)));
    end
  end

  assign raddr_o = rptr_q[AW-1:0];

  // R3
  rptr_step_chk: assert property (@(posedge rclk_i) disable iff (!rst_ni)
    !jump |=> (rptr_q == $past(rptr_q) || rptr_q == $past(rptr_q) + PW'(1)));

  // R6
  occ_bound_chk: assert property (@(posedge rclk_i) disable iff (!rst_ni)
    run_q |-> occ <= PW'(DEPTH));

  // R2
  no_read_idle_chk: assert property (@(posedge rclk_i) disable iff (!rst_ni)
    !run_q |-> !re_o);
endmodule

// File: rtl/dejitter_buf.sv
module dejitter_buf
  import dj_pkg::*;
#(
  parameter int unsigned DEPTH = 128,
  parameter int unsigned LIM = 4
) (
  input  logic wclk_i,
  input  logic rclk_i,
  input  logic rst_ni,
  input  logic pos_i,
  input  logic neg_i,
  input  logic recenter_ni,
  input  logic bypass_i,
  output logic pos_o,
  output logic neg_o,
  output logic limit_o
);
  localparam int unsigned AW = $clog2(DEPTH);
  localparam int unsigned PW = AW + 1;

  logic [AW-1:0] waddr, raddr;
  logic [PW-1:0] wgray, wgray_s;
  logic          re;
  sym_t          wsym, rsym;

  assign wsym = '{p: pos_i, n: neg_i};

  dj_wr_ctl #(.DEPTH(DEPTH)) u_wr (
    .wclk_i (wclk_i),
    .rst_ni (rst_ni),
    .waddr_o(waddr),
    .wgray_o(wgray)
  );

  dj_sync #(.W(PW)) u_wsync (
    .clk_i (rclk_i),
    .rst_ni(rst_ni),
    .d_i   (wgray),
    .q_o   (wgray_s)
  );

  dj_ram #(.DEPTH(DEPTH)) u_ram (
    .wclk_i (wclk_i),
    .waddr_i(waddr),
    .wdata_i(wsym),
    .rclk_i (rclk_i),
    .rst_ni (rst_ni),
    .re_i   (re),
    .raddr_i(raddr),
    .rdata_o(rsym)
  );

  dj_rd_ctl #(.DEPTH(DEPTH), .LIM(LIM)) u_rd (
    .rclk_i     (rclk_i),
    .rst_ni     (rst_ni),
    .wgray_i    (wgray_s),
    .recenter_ni(recenter_ni),
    .re_o       (re),
    .raddr_o    (raddr),
    .limit_o    (limit_o)
  );

  assign pos_o = bypass_i ? pos_i : rsym.p;
  assign neg_o = bypass_i ? neg_i : rsym.n;

  // R8
  bypass_pass_chk: assert property (@(posedge rclk_i) disable iff (!rst_ni)
    bypass_i |-> (pos_o == pos_i && neg_o == neg_i));
endmodule

// File: tb/dejitter_buf_tb_top.sv
`timescale 1ns/1ps
module dejitter_buf_tb_top;
  logic wclk = 1'b0, rclk = 1'b0, rst_n = 1'b0;
  logic pos_i = 1'b0, neg_i = 1'b1, rc_n = 1'b1, byp = 1'b0;
  logic pos_o, neg_o, limit_o;
  real  whalf = 2.0;
  int   n_vec = 0, n_fail = 0;
  logic [6:0] lfsr = 7'h5a;

  dejitter_buf dut_i (
    .wclk_i(wclk), .rclk_i(rclk), .rst_ni(rst_n),
    .pos_i(pos_i), .neg_i(neg_i), .recenter_ni(rc_n), .bypass_i(byp),
    .pos_o(pos_o), .neg_o(neg_o), .limit_o(limit_o)
  );

  always #2 rclk = ~rclk;
  initial begin
    #0.7;
    forever #(whalf) wclk = ~wclk;
  end

  // x^7+x^6+1 sequence: b[n] = b[n-6] ^ b[n-7]
  always @(negedge wclk) begin
    lfsr  <= {lfsr[5:0], lfsr[5] ^ lfsr[6]};
    pos_i <= lfsr[5] ^ lfsr[6];
    neg_i <= ~(lfsr[5] ^ lfsr[6]);
  end

  // stream monitor
  logic       mon_en = 1'b0;
  logic [6:0] hist = '0;
  int         mon_n = 0, mon_err = 0, lim_hi = 0, lim_rise = 0, tog = 0;
  logic       lim_prev = 1'b0, pos_prev = 1'b0;
  always @(negedge rclk) begin
    if (mon_en) begin
      if (mon_n >= 8 && (pos_o !== (hist[5] ^ hist[6]) || neg_o !== ~pos_o))
        mon_err++;
      hist  <= {hist[5:0], pos_o};
      mon_n++;
    end
    if (limit_o) lim_hi++;
    if (limit_o && !lim_prev) lim_rise++;
    if (pos_o != pos_prev) tog++;
    lim_prev <= limit_o;
    pos_prev <= pos_o;
  end

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    n_vec++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic wait_r(input int n);
    repeat (n) @(negedge rclk);
  endtask

  task automatic clr_stats();
    lim_hi = 0; lim_rise = 0; tog = 0;
  endtask

  task automatic t_reset();
    wait_r(5);
    chk(pos_o == 0 && neg_o == 0, "R1 outputs in reset", {pos_o, neg_o}, 0);
    chk(limit_o == 0, "R1 limit in reset", limit_o, 0);
    rst_n = 1'b1;
    wait_r(1);
    chk(pos_o == 0 && neg_o == 0 && limit_o == 0, "R1 after release",
        {pos_o, neg_o, limit_o}, 0);
  endtask

  task automatic t_fill();
    clr_stats();
    wait_r(30);
    chk(pos_o == 0 && neg_o == 0, "R2 held while filling", {pos_o, neg_o}, 0);
    chk(lim_hi == 0, "R2 limit low while filling", lim_hi, 0);
    wait_r(100);
    chk(pos_o != neg_o, "R2 stream started", {pos_o, neg_o}, 1);
  endtask

  task automatic t_steady(input string tag);
    clr_stats();
    mon_n = 0; mon_err = 0; mon_en = 1'b1;
    wait_r(400);
    mon_en = 1'b0;
    chk(mon_err == 0, {tag, " in-order stream"}, mon_err, 0);
    chk(mon_n >= 400, {tag, " samples"}, mon_n, 400);
    chk(lim_hi == 0, {tag, " limit low"}, lim_hi, 0);
  endtask

  task automatic t_recenter();
    clr_stats();
    rc_n = 1'b0;
    wait_r(40);
    chk(lim_hi == 0, "R4 no action while low", lim_hi, 0);
    rc_n = 1'b1;
    wait_r(60);
    chk(lim_hi == 1, "R4 one limit cycle per pulse", lim_hi, 1);
    chk(tog > 0, "R4 stream continues", tog, 1);
  endtask

  task automatic t_fast();
    clr_stats();
    whalf = 1.8;
    wait_r(3000);
    whalf = 2.0;
    chk(lim_hi > 0, "R5 limit near full", lim_hi, 1);
    chk(lim_rise >= 2, "R6 auto recenter repeats", lim_rise, 2);
    chk(tog > 100, "R6 output keeps running", tog, 100);
    wait_r(20);
    t_recenter();
  endtask

  task automatic t_slow();
    clr_stats();
    whalf = 2.2;
    wait_r(3000);
    whalf = 2.0;
    chk(lim_hi > 0, "R7 limit near empty", lim_hi, 1);
    chk(lim_rise >= 2, "R7 recovers by recentering", lim_rise, 2);
    chk(tog > 100, "R7 output keeps running", tog, 100);
    wait_r(20);
    t_recenter();
  endtask

  task automatic t_bypass();
    byp = 1'b1;
    for (int i = 0; i < 20; i++) begin
      @(posedge wclk);
      #0.5;
      chk(pos_o == pos_i && neg_o == neg_i, "R8 bypass passes data",
          {pos_o, neg_o}, {pos_i, neg_i});
    end
    byp = 1'b0;
    wait_r(2);
  endtask

  initial begin
    #800000;
    n_fail++;
    $display("FAIL watchdog actual=%0d expected=%0d", 1, 0);
    $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_fail);
    $finish;
  end

  initial begin
    t_reset();
    t_fill();
    t_steady("R3");
    t_recenter();
    t_steady("R3 after R4");
    t_fast();
    t_steady("R3 after R6");
    t_slow();
    t_steady("R3 after R7");
    t_bypass();
    t_steady("R3 after R8");
    $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_fail);
    $finish;
  end
endmodule